// File: doc/BRIEF.md
# Per-Pattern-Edge Jitter Averager

This block takes a stream of signed time interval error samples, one per cycle when valid, that were captured so that each sample belongs to the pattern edge following the previous sample's edge. Edge positions repeat with the pattern's edge count N. The block keeps a running sum and a sample count for every edge position. When every edge has collected M samples, it divides each sum by M. Averaging this way removes jitter that is not correlated with the pattern. What remains is each edge's data-dependent shift.

In the result phase the block streams out the per-edge means in edge order. It tracks the largest and smallest mean and reports their difference as the peak-to-peak data-dependent jitter, then raises a sticky done flag. A start pulse loads a new N (up to 256; 64 is typical) and a new M (up to 1023). It also zeroes the per-edge memory and begins a new measurement.

Top module: `ddj_edge_avg`

## Requirements
- R1: A start pulse loads N from cfg_edges (0 is taken as 1, values above 256 as 256) and M from cfg_m (0 is taken as 1). It lowers done, sets ddj_pp to 0 and zeroes every edge's sum and count during the N cycles after the start edge. Samples presented during those N cycles are ignored, and so are sums left from earlier runs.
- R2: Every sample accepted after the clear goes to the current edge position. That position is 0 for the first accepted sample and advances by one, wrapping from N-1 to 0, on each accepted sample. Cycles with smp_valid low do not advance it.
- R3: Accumulation stops with the sample that gives edge N-1 its M-th sample. Samples presented after that are ignored until the next start.
- R4: In the result phase, res_valid pulses once per edge in ascending index order 0 to N-1. With each pulse, res_idx gives the edge and res_mean gives that edge's sum divided by M, truncated toward zero.
- R5: When done is high, ddj_pp equals the largest per-edge mean minus the smallest, as an unsigned value one bit wider than a sample.
- R6: done rises after the last result pulse and stays high, with ddj_pp unchanged, until the next start or reset.
- R7: Full-scale samples (-32768 or 32767) accumulated M=1023 times do not overflow. Their means come back exactly, and a pair of opposite full-scale edges yields ddj_pp = 65535.
- R8: Synchronous active-high reset clears done, res_valid and ddj_pp to 0.
- R9: With N=1 every sample lands on edge 0, and ddj_pp is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new measurement: load the configuration and clear the memory |
| cfg_edges | input | 9 | Pattern edge count N, 1 to 256 |
| cfg_m | input | 10 | Samples per edge M, 1 to 1023 |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_tie | input | 16 | Signed time interval error sample |
| res_valid | output | 1 | One-cycle pulse: a per-edge mean is on res_idx/res_mean |
| res_idx | output | 8 | Edge index of the current mean |
| res_mean | output | 16 | Signed mean of that edge |
| ddj_pp | output | 17 | Peak-to-peak data-dependent jitter (largest mean minus smallest) |
| done | output | 1 | Measurement complete; the result holds |

## Verification
Two situations are hard to reach from the ports. The first is a pair of extreme means produced by full-scale sums. The stimulus feeds 1023 samples of full-scale values to one and two edges, which takes the sums to their widest magnitude and the range to 65535. The second is the clear window. Each run begins with the memory still full of the previous run's sums, and the stimulus holds smp_valid high with large junk values throughout the N clear cycles. Any surviving sum or accepted junk sample would show in the means. The stimulus also inserts idle cycles within the sample stream and drives trailing samples after accumulation ends.

// File: rtl/ddj_pkg.sv
package ddj_pkg;

    localparam int SAMPLE_W_DEF  = 16;
    localparam int MAX_EDGES_DEF = 256;
    localparam int MAX_M_DEF     = 1023;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACCUM,
        ST_RES_GO,
        ST_RES_WAIT,
        ST_FINISH,
        ST_DONE
    } avg_state_t;

    // Clamp a requested count into 1..limit.
    function automatic int clamp_count(int req, int limit);
        if (req < 1)
            return 1;
        else if (req > limit)
            return limit;
        else
            return req;
    endfunction

endpackage

// File: rtl/ddj_edge_store.sv
module ddj_edge_store #(
    parameter int DEPTH  = 256,
    parameter int SUM_W  = 26,
    parameter int CNT_W  = 10,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic signed [SUM_W-1:0] wr_sum,
    input  logic [CNT_W-1:0]        wr_cnt,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic signed [SUM_W-1:0] rd_sum,
    output logic [CNT_W-1:0]        rd_cnt
);

    logic signed [SUM_W-1:0] sum_mem [DEPTH];
    logic [CNT_W-1:0]        cnt_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            sum_mem[wr_addr] <= wr_sum;
            cnt_mem[wr_addr] <= wr_cnt;
        end
    end

    assign rd_sum = sum_mem[rd_addr];
    assign rd_cnt = cnt_mem[rd_addr];

endmodule

// File: rtl/ddj_seq_div.sv
module ddj_seq_div #(
    parameter int DVD_W  = 26,
    parameter int DVS_W  = 10,
    parameter int OUT_W  = 16,
    localparam int STEP_W = $clog2(DVD_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0]        divisor,
    output logic                    done,
    output logic signed [OUT_W-1:0] quotient
);

    logic              busy;
    logic [STEP_W-1:0] step;
    logic [DVS_W:0]    rem;
    logic [DVD_W-1:0]  quo;
    logic [DVS_W-1:0]  dvs;
    logic              neg;
    logic [DVS_W:0]    rem_sh;
    logic              ge;

    assign rem_sh = (rem << 1) | {{DVS_W{1'b0}}, quo[DVD_W-1]};
    assign ge     = rem_sh >= {1'b0, dvs};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            step <= '0;
            rem  <= '0;
            quo  <= '0;
            dvs  <= '0;
            neg  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                step <= '0;
                rem  <= '0;
                quo  <= dividend[DVD_W-1] ? DVD_W'(-dividend) : DVD_W'(dividend);
                neg  <= dividend[DVD_W-1];
                dvs  <= divisor;
            end else if (busy) begin
                rem  <= ge ? (rem_sh - {1'b0, dvs}) : rem_sh;
                quo  <= {quo[DVD_W-2:0], ge};
                step <= step + STEP_W'(1);
                if (step == STEP_W'(DVD_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = neg ? -$signed(quo[OUT_W-1:0]) : $signed(quo[OUT_W-1:0]);

    AST_DIV_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)) else $error("divider done without a busy run"); // R4

endmodule

// File: rtl/ddj_range_track.sv
module ddj_range_track #(
    parameter int VAL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    upd,
    input  logic signed [VAL_W-1:0] val,
    output logic signed [VAL_W-1:0] vmax,
    output logic signed [VAL_W-1:0] vmin
);

    logic empty;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            empty <= 1'b1;
            vmax  <= '0;
            vmin  <= '0;
        end else if (upd) begin
            empty <= 1'b0;
            if (empty || val > vmax) vmax <= val;
            if (empty || val < vmin) vmin <= val;
        end
    end

endmodule

// File: rtl/ddj_edge_avg.sv
module ddj_edge_avg
    import ddj_pkg::*;
#(
    parameter int SAMPLE_W  = SAMPLE_W_DEF,
    parameter int MAX_EDGES = MAX_EDGES_DEF,
    parameter int MAX_M     = MAX_M_DEF,
    localparam int EDGE_W   = $clog2(MAX_EDGES),
    localparam int NUM_W    = EDGE_W + 1,
    localparam int CNT_W    = $clog2(MAX_M + 1),
    localparam int SUM_W    = SAMPLE_W + CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [NUM_W-1:0]           cfg_edges,
    input  logic [CNT_W-1:0]           cfg_m,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_tie,
    output logic                       res_valid,
    output logic [EDGE_W-1:0]          res_idx,
    output logic signed [SAMPLE_W-1:0] res_mean,
    output logic [SAMPLE_W:0]          ddj_pp,
    output logic                       done
);

    avg_state_t              state;
    logic [NUM_W-1:0]        num_q;
    logic [CNT_W-1:0]        m_q;
    logic [EDGE_W-1:0]       ptr;
    logic [EDGE_W-1:0]       last_idx;
    logic                    at_last;

    logic                    mem_we;
    logic signed [SUM_W-1:0] mem_wsum;
    logic [CNT_W-1:0]        mem_wcnt;
    logic signed [SUM_W-1:0] rd_sum;
    logic [CNT_W-1:0]        rd_cnt;
    logic [CNT_W-1:0]        cnt_nx;
    logic signed [SUM_W-1:0] tie_ext;
    logic                    acc_take;
    logic                    acc_finish;

    logic                    div_start;
    logic                    div_done;
    logic signed [SAMPLE_W-1:0] div_q;
    logic signed [SAMPLE_W-1:0] rng_max;
    logic signed [SAMPLE_W-1:0] rng_min;
    logic signed [SAMPLE_W:0]   span;

    assign last_idx   = EDGE_W'(num_q - NUM_W'(1));
    assign at_last    = (ptr == last_idx);
    assign tie_ext    = {{(SUM_W-SAMPLE_W){smp_tie[SAMPLE_W-1]}}, smp_tie};
    assign cnt_nx     = rd_cnt + CNT_W'(1);
    assign acc_take   = (state == ST_ACCUM) && smp_valid;
    assign acc_finish = acc_take && at_last && (cnt_nx == m_q);

    assign mem_we   = (state == ST_CLEAR) || acc_take;
    assign mem_wsum = (state == ST_CLEAR) ? '0 : rd_sum + tie_ext;
    assign mem_wcnt = (state == ST_CLEAR) ? '0 : cnt_nx;
    assign div_start = (state == ST_RES_GO);
    assign span     = {rng_max[SAMPLE_W-1], rng_max} - {rng_min[SAMPLE_W-1], rng_min};

    ddj_edge_store #(
        .DEPTH (MAX_EDGES),
        .SUM_W (SUM_W),
        .CNT_W (CNT_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (ptr),
        .wr_sum  (mem_wsum),
        .wr_cnt  (mem_wcnt),
        .rd_addr (ptr),
        .rd_sum  (rd_sum),
        .rd_cnt  (rd_cnt)
    );

    ddj_seq_div #(
        .DVD_W (SUM_W),
        .DVS_W (CNT_W),
        .OUT_W (SAMPLE_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (rd_sum),
        .divisor  (m_q),
        .done     (div_done),
        .quotient (div_q)
    );

    ddj_range_track #(
        .VAL_W (SAMPLE_W)
    ) u_range (
        .clk  (clk),
        .rst  (rst),
        .clr  (acc_finish),
        .upd  ((state == ST_RES_WAIT) && div_done),
        .val  (div_q),
        .vmax (rng_max),
        .vmin (rng_min)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            num_q     <= NUM_W'(1);
            m_q       <= CNT_W'(1);
            ptr       <= '0;
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_mean  <= '0;
            ddj_pp    <= '0;
            done      <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (start) begin
                state  <= ST_CLEAR;
                num_q  <= NUM_W'(clamp_count(int'(cfg_edges), MAX_EDGES));
                m_q    <= CNT_W'(clamp_count(int'(cfg_m), MAX_M));
                ptr    <= '0;
                done   <= 1'b0;
                ddj_pp <= '0;
            end else begin
                unique case (state)
                    ST_CLEAR: begin
                        ptr <= at_last ? '0 : ptr + EDGE_W'(1);
                        if (at_last) state <= ST_ACCUM;
                    end
                    ST_ACCUM: begin
                        if (acc_take) begin
                            ptr <= at_last ? '0 : ptr + EDGE_W'(1);
                            if (acc_finish) state <= ST_RES_GO;
                        end
                    end
                    ST_RES_GO: state <= ST_RES_WAIT;
                    ST_RES_WAIT: begin
                        if (div_done) begin
                            res_valid <= 1'b1;
                            res_idx   <= ptr;
                            res_mean  <= div_q;
                            if (at_last) begin
                                state <= ST_FINISH;
                            end else begin
                                ptr   <= ptr + EDGE_W'(1);
                                state <= ST_RES_GO;
                            end
                        end
                    end
                    ST_FINISH: begin
                        ddj_pp <= span[SAMPLE_W:0];
                        done   <= 1'b1;
                        state  <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> ({1'b0, ptr} < num_q)) else $error("edge pointer beyond N"); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        acc_take |-> (rd_cnt < m_q)) else $error("edge collected more than M samples"); // R3

    AST_RES_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ({1'b0, res_idx} < num_q)) else $error("result index beyond N"); // R4

    AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        done |-> (rng_max >= rng_min)) else $error("range maximum below minimum"); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(ddj_pp))) else $error("done or result moved"); // R6

endmodule

// File: tb/ddj_edge_avg_tb.sv
module ddj_edge_avg_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [8:0]         cfg_edges = '0;
    logic [9:0]         cfg_m = '0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_tie = '0;
    logic               res_valid;
    logic [7:0]         res_idx;
    logic signed [15:0] res_mean;
    logic [16:0]        ddj_pp;
    logic               done;

    int checks = 0;
    int fails  = 0;

    longint exp_sum  [256];
    int     got_mean [256];
    int     mon_cnt;
    int     mon_next;

    // n, m, seed, mode (0 pattern+noise, 1 all -32768, 2 even +32767 / odd -32768)
    localparam int TBL [5][4] = '{
        '{4,   8,    1, 0},
        '{64,  100,  3, 0},
        '{1,   1023, 0, 1},
        '{2,   1023, 0, 2},
        '{256, 2,    5, 0}
    };

    always #4 clk = ~clk;

    ddj_edge_avg u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_edges (cfg_edges),
        .cfg_m     (cfg_m),
        .smp_valid (smp_valid),
        .smp_tie   (smp_tie),
        .res_valid (res_valid),
        .res_idx   (res_idx),
        .res_mean  (res_mean),
        .ddj_pp    (ddj_pp),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (res_valid) begin
            check(int'(res_idx) == mon_next, "R4 result order", res_idx, mon_next);
            got_mean[res_idx] = res_mean;
            mon_next = mon_next + 1;
            mon_cnt  = mon_cnt + 1;
        end
    end

    function automatic int tie_of(int e, int k, int seed, int mode);
        if (mode == 1) return -32768;
        if (mode == 2) return (e % 2 == 0) ? 32767 : -32768;
        return (((e * 37 + seed * 11) % 61) - 30) + (((k * 13 + e * 7 + seed) % 21) - 10);
    endfunction

    task automatic run_case(input int n, input int m_req, input int seed, input int mode);
        int m;
        int v;
        longint mx;
        longint mn;
        int waited;
        logic [16:0] pp_hold;
        m = (m_req < 1) ? 1 : m_req;
        for (int e = 0; e < 256; e++) exp_sum[e] = 0;
        @(negedge clk);
        mon_cnt = 0;
        mon_next = 0;
        start = 1'b1;
        cfg_edges = 9'(n);
        cfg_m = 10'(m_req);
        smp_valid = 1'b1;
        smp_tie = 16'sd12345;
        @(negedge clk);
        start = 1'b0;
        // R1: junk during the clear window must be ignored
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1;
            smp_tie = 16'(20000 + i);
            @(negedge clk);
        end
        for (int k = 0; k < m; k++) begin
            for (int e = 0; e < n; e++) begin
                if (((k * n + e) % 7) == 3) begin
                    smp_valid = 1'b0;
                    smp_tie = 16'sd9999;
                    @(negedge clk);
                end
                v = tie_of(e, k, seed, mode);
                exp_sum[e] += v;
                smp_valid = 1'b1;
                smp_tie = 16'(v);
                @(negedge clk);
            end
        end
        // R3: trailing samples after accumulation are ignored
        for (int i = 0; i < 5; i++) begin
            smp_valid = 1'b1;
            smp_tie = 16'sd30000;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R6 done rises", done, 1);
        check(mon_cnt == n, "R4 result count", mon_cnt, n);
        mx = -100000;
        mn = 100000;
        for (int e = 0; e < n; e++) begin
            longint em;
            em = exp_sum[e] / m;
            if (em > mx) mx = em;
            if (em < mn) mn = em;
            check(got_mean[e] == em, (mode != 0) ? "R7 R1 R2 mean" : "R1 R2 R4 mean", got_mean[e], em);
        end
        check(longint'(ddj_pp) == mx - mn, (n == 1) ? "R9 R5 pp" : "R5 pp", ddj_pp, mx - mn);
        pp_hold = ddj_pp;
        for (int i = 0; i < 10; i++) begin
            smp_valid = 1'b1;
            smp_tie = 16'(-5000 * (i + 1));
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(done == 1'b1 && ddj_pp == pp_hold, "R6 R3 result holds", ddj_pp, pp_hold);
        check(mon_cnt == n, "R3 no extra results", mon_cnt, n);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        mon_cnt = 0;
        mon_next = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 reset done", done, 0);
        check(res_valid == 1'b0, "R8 reset res_valid", res_valid, 0);
        check(ddj_pp == 17'd0, "R8 reset ddj_pp", ddj_pp, 0);

        for (int t = 0; t < 5; t++)
            run_case(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3]);

        // R1: M requested as 0 behaves as M=1
        run_case(3, 0, 7, 0);

        // R8: reset after a finished run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 reset after run done", done, 0);
        check(ddj_pp == 17'd0, "R8 reset after run pp", ddj_pp, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule